// File: doc/BRIEF.md
# Cache-Line Sub-Completion Reorder Buffer

This block sits between a requester and an unordered memory fabric. A single read of up to 64 cache lines (64 bytes each, so up to 4 KB) is accepted as a base address and a line count. A counter then emits one line-sized sub-request per handshake, in ascending address order.

The fabric may return the line data in any order. Every returned line goes into a per-line slot, and a bitmap records which slots are filled. A read pointer walks the slots upward. It sends a line to the requester as eight 64-bit beats, but only when that line's slot is filled. A line that arrives early therefore waits until all lines below it have gone out.

Returns that cannot belong to the active request are flagged and discarded. A new request is taken only after the last beat of the previous one has been delivered.

Top module: `line_reorder_buf`

## Requirements
- R1: After reset, req_ready is 1, and out_valid, iss_valid and ret_err are all 0.
- R2: A request is taken on a cycle with req_valid and req_ready both high. req_last holds the line count minus one (0 to 63). req_ready is low from the next cycle until the final beat has been handed over. It is high again in the cycle after that. A request offered while busy is ignored and leaves the issued addresses unchanged.
- R3: iss_valid presents the sub-request addresses base + 64*k for k = 0 up to req_last, one per iss_ready handshake, in ascending order. The base has its low 6 bits forced to zero, and the sum wraps modulo 2^ADDR_W.
- R4: Lines may be returned in any order through ret_valid, ret_idx and ret_data. Beat b of a line is carried in ret_data bits [64*b+63 : 64*b].
- R5: Lines are delivered in ascending index order, each as 8 beats with beat 0 first. out_valid stays low while the line at the pointer has not arrived, even if higher lines have.
- R6: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold their values.
- R7: out_last is high only on the final beat of the final line of the request.
- R8: ret_err is high in the cycle after a return that is dropped: an index above req_last, a second return of the same index, or any return while idle. A dropped return leaves the stored data unchanged.
- R9: A line returned in cycle t while the pointer already waits on it raises out_valid in cycle t+1. A return can be stored in the same cycle a beat is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_base | input | ADDR_W | Byte base address of the read |
| req_last | input | log2(MAX_LINES) | Line count minus one |
| iss_valid | output | 1 | Sub-request pending |
| iss_ready | input | 1 | Fabric takes the sub-request |
| iss_addr | output | ADDR_W | Line-aligned sub-request address |
| ret_valid | input | 1 | Line data returned |
| ret_idx | input | log2(MAX_LINES) | Line index of the return |
| ret_data | input | LINE_BYTES*8 | Whole line, beat 0 in the low bits |
| ret_err | output | 1 | Previous cycle's return was dropped |
| out_valid | output | 1 | Output beat available |
| out_ready | input | 1 | Requester takes the beat |
| out_data | output | DATA_W | Output beat |
| out_last | output | 1 | Final beat of the final line |

## Verification
The return port and the delivery port act independently, so a line can be written into its slot in the same cycle that a beat of a lower line is handed over. It can even be the very line the pointer moves onto next. The bench provokes this by feeding returns in ascending, descending, interleaved, rotated and pair-swapped orders while out_ready runs steady or with stalls. Every beat is judged against data computed from its line index and beat number, which exposes any early release, lost write or skipped line.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
   typedef enum logic {
      LRB_IDLE = 1'b0,
      LRB_BUSY = 1'b1
   } lrb_state_e;
endpackage

// File: rtl/lrb_issue.sv
module lrb_issue #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 6,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              active,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [IDX_W-1:0]  last_idx,
   output logic              iss_valid,
   input  logic              iss_ready,
   output logic [ADDR_W-1:0] iss_addr
);
   localparam int HI_W = ADDR_W - OFF_W;

   logic [IDX_W:0]  cnt_q;
   logic [HI_W-1:0] base_q;
   logic            fire;
   logic            final_one;

   assign iss_valid = active && (cnt_q <= {1'b0, last_idx});
   assign fire      = iss_valid && iss_ready;
   assign final_one = (cnt_q == {1'b0, last_idx});
   assign iss_addr  = {base_q + HI_W'(cnt_q), {OFF_W{1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         base_q <= '0;
      end else if (start) begin
         cnt_q  <= '0;
         base_q <= req_base[ADDR_W-1:OFF_W];
      end else if (fire) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   AST_ISSUE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !final_one) |=> (!iss_valid || iss_addr == $past(iss_addr) + ADDR_W'(1 << OFF_W))); // R3
endmodule

// File: rtl/lrb_store.sv
module lrb_store #(
   parameter int NLINES = 64,
   parameter int IDX_W  = 6,
   parameter int LINE_W = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              active,
   input  logic [IDX_W-1:0]  last_idx,
   input  logic              ret_valid,
   input  logic [IDX_W-1:0]  ret_idx,
   input  logic [LINE_W-1:0] ret_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [LINE_W-1:0] rd_line,
   output logic [NLINES-1:0] arrived,
   output logic              ret_err
);
   logic [LINE_W-1:0] slot [NLINES];
   logic              take;

   assign take    = ret_valid && active && (ret_idx <= last_idx) && !arrived[ret_idx];
   assign rd_line = slot[rd_idx];

   for (genvar g = 0; g < NLINES; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (take && ret_idx == IDX_W'(g)) slot[g] <= ret_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arrived <= '0;
         ret_err <= 1'b0;
      end else begin
         ret_err <= ret_valid && !take;
         if (start)     arrived <= '0;
         else if (take) arrived[ret_idx] <= 1'b1;
      end
   end

   AST_REJECT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && !take && !start) |=> ($countones(arrived) == $past($countones(arrived)))); // R8
   AST_ACCEPT_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> arrived[$past(ret_idx)]); // R4
endmodule

// File: rtl/lrb_drain.sv
module lrb_drain #(
   parameter int NLINES = 64,
   parameter int IDX_W  = 6,
   parameter int LINE_W = 512,
   parameter int DATA_W = 64,
   parameter int BEATS  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              active,
   input  logic [IDX_W-1:0]  last_idx,
   input  logic [NLINES-1:0] arrived,
   input  logic [LINE_W-1:0] rd_line,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   output logic              done
);
   localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

   logic fire;
   logic line_end;

   assign out_valid = active && arrived[rd_idx];
   assign fire      = out_valid && out_ready;
   assign out_last  = line_end && (rd_idx == last_idx);
   assign done      = fire && out_last;

   if (BEATS == 1) begin : g_single
      assign line_end = 1'b1;
      assign out_data = rd_line[DATA_W-1:0];
   end else begin : g_multi
      localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BEATS - 1);
      logic [BEAT_W-1:0] beat_q;
      assign line_end = (beat_q == BEAT_LAST);
      assign out_data = rd_line[beat_q*DATA_W +: DATA_W];
      always_ff @(posedge clk) begin
         if (!rst_n || start) beat_q <= '0;
         else if (fire)       beat_q <= line_end ? '0 : beat_q + 1'b1;
      end
      AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         (fire && !line_end) |=> (beat_q == $past(beat_q) + 1'b1)); // R5
   end

   always_ff @(posedge clk) begin
      if (!rst_n || start)     rd_idx <= '0;
      else if (fire && line_end) rd_idx <= rd_idx + 1'b1;
   end

   AST_PTR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !start) |=> (!active || rd_idx >= $past(rd_idx))); // R5
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R6
endmodule

// File: rtl/line_reorder_buf.sv
module line_reorder_buf #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int DATA_W     = 64,
   parameter int MAX_LINES  = 64,
   localparam int IDX_W     = $clog2(MAX_LINES),
   localparam int LINE_W    = LINE_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [IDX_W-1:0]  req_last,
   output logic              iss_valid,
   input  logic              iss_ready,
   output logic [ADDR_W-1:0] iss_addr,
   input  logic              ret_valid,
   input  logic [IDX_W-1:0]  ret_idx,
   input  logic [LINE_W-1:0] ret_data,
   output logic              ret_err,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last
);
   import lrb_pkg::*;

   localparam int OFF_W = $clog2(LINE_BYTES);
   localparam int BEATS = LINE_W / DATA_W;

   if ((1 << IDX_W) != MAX_LINES) begin : g_chk_lines
      $error("MAX_LINES must be a power of two");
   end
   if ((1 << OFF_W) != LINE_BYTES) begin : g_chk_line
      $error("LINE_BYTES must be a power of two");
   end
   if (BEATS * DATA_W != LINE_W) begin : g_chk_beats
      $error("DATA_W must divide the line width");
   end
   if (ADDR_W <= OFF_W) begin : g_chk_addr
      $error("ADDR_W too small for the line offset");
   end

   lrb_state_e              state_q;
   logic                    active;
   logic                    start;
   logic                    done;
   logic [IDX_W-1:0]        last_q;
   logic [IDX_W-1:0]        rd_idx;
   logic [LINE_W-1:0]       rd_line;
   logic [MAX_LINES-1:0]    arrived;

   assign active    = (state_q == LRB_BUSY);
   assign req_ready = !active;
   assign start     = req_valid && !active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= LRB_IDLE;
         last_q  <= '0;
      end else if (start) begin
         state_q <= LRB_BUSY;
         last_q  <= req_last;
      end else if (done) begin
         state_q <= LRB_IDLE;
      end
   end

   lrb_issue #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_issue (
      .clk(clk), .rst_n(rst_n), .start(start), .active(active),
      .req_base(req_base), .last_idx(last_q),
      .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_addr(iss_addr)
   );

   lrb_store #(.NLINES(MAX_LINES), .IDX_W(IDX_W), .LINE_W(LINE_W)) i_store (
      .clk(clk), .rst_n(rst_n), .start(start), .active(active),
      .last_idx(last_q), .ret_valid(ret_valid), .ret_idx(ret_idx),
      .ret_data(ret_data), .rd_idx(rd_idx), .rd_line(rd_line),
      .arrived(arrived), .ret_err(ret_err)
   );

   lrb_drain #(.NLINES(MAX_LINES), .IDX_W(IDX_W), .LINE_W(LINE_W),
               .DATA_W(DATA_W), .BEATS(BEATS)) i_drain (
      .clk(clk), .rst_n(rst_n), .start(start), .active(active),
      .last_idx(last_q), .arrived(arrived), .rd_line(rd_line),
      .rd_idx(rd_idx), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_last(out_last), .done(done)
   );

   AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> req_ready); // R2
   AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !done) |=> active); // R2
endmodule

// File: tb/test_line_reorder_buf.sv
`timescale 1ns/1ps
module test_line_reorder_buf;
   localparam int ADDR_W = 32;
   localparam int DATA_W = 64;
   localparam int BEATS  = 8;
   localparam int LINE_W = 512;
   localparam int LIMIT  = 150000;

   // columns: last index, arrival order, ready pattern, base, poke while busy
   localparam int N_VEC = 6;
   localparam int VEC [N_VEC][5] = '{
      '{63, 2, 0, 32'h1000_0000, 0},
      '{63, 1, 1, 32'h0000_4000, 1},
      '{ 0, 0, 0, 32'h0000_007F, 0},
      '{ 7, 3, 2, 32'hFFFF_FFC0, 1},
      '{10, 4, 1, 32'h0000_0200, 0},
      '{31, 0, 0, 32'h0000_3000, 0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [ADDR_W-1:0] req_base = '0;
   logic [5:0]        req_last = '0;
   logic              iss_valid;
   logic              iss_ready = 1'b1;
   logic [ADDR_W-1:0] iss_addr;
   logic              ret_valid = 1'b0;
   logic [5:0]        ret_idx = '0;
   logic [LINE_W-1:0] ret_data = '0;
   logic              ret_err;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [DATA_W-1:0] out_data;
   logic              out_last;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   line_reorder_buf i_line_reorder_buf (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_base(req_base), .req_last(req_last), .iss_valid(iss_valid),
      .iss_ready(iss_ready), .iss_addr(iss_addr), .ret_valid(ret_valid),
      .ret_idx(ret_idx), .ret_data(ret_data), .ret_err(ret_err),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_last(out_last)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] beat_val(input int tag, input int idx, input int b);
      return {16'(tag), 16'(idx), 16'(b), 16'hC0DE};
   endfunction

   function automatic logic [LINE_W-1:0] line_val(input int tag, input int idx);
      logic [LINE_W-1:0] v;
      for (int b = 0; b < BEATS; b++) v[b*DATA_W +: DATA_W] = beat_val(tag, idx, b);
      return v;
   endfunction

   function automatic int arrival(input int order, input int n, input int k);
      int h;
      case (order)
         1: return n - 1 - k;
         2: begin h = n / 2; return (k < h) ? 2*k + 1 : 2*(k - h); end
         3: return (k + 3) % n;
         4: return ((k ^ 1) < n) ? (k ^ 1) : k;
         default: return k;
      endcase
   endfunction

   function automatic bit ready_at(input int pat, input int cyc);
      case (pat)
         1: return cyc % 2 == 0;
         2: return cyc % 4 == 3;
         default: return 1'b1;
      endcase
   endfunction

   // Consumer: expects n lines in ascending order (R5, R6, R7).
   task automatic drain_expect(input int n, input int tag, input int pat);
      int k = 0;
      int cyc = 0;
      bit held = 0;
      logic [63:0] held_data = '0;
      while (k < n*BEATS) begin
         if (held) check(out_valid && out_data == held_data, "R6 hold", out_data, held_data);
         out_ready = ready_at(pat, cyc);
         held = out_valid && !out_ready;
         held_data = out_data;
         if (out_valid && out_ready) begin
            check(out_data == beat_val(tag, k / BEATS, k % BEATS), "R5 order", out_data,
                  beat_val(tag, k / BEATS, k % BEATS));
            check(out_last == (k == n*BEATS - 1), "R7 last", 64'(out_last), 64'(k == n*BEATS - 1));
            k++;
         end
         cyc++;
         @(negedge clk);
      end
      out_ready = 1'b0;
   endtask

   task automatic issue_expect(input int n, input logic [31:0] base);
      int k = 0;
      logic [31:0] exp;
      while (k < n) begin
         if (iss_valid) begin
            exp = {base[31:6], 6'b0} + 32'(64*k);
            check(iss_addr == exp, "R3 issue", 64'(iss_addr), 64'(exp));
            k++;
         end
         @(negedge clk);
      end
   endtask

   task automatic feed(input int n, input int order, input int pat, input int tag, input int poke);
      int k = 0;
      int cyc = 0;
      while (k < n) begin
         if (poke != 0 && cyc == 0) begin
            check(req_ready == 1'b0, "R2 busy", 64'(req_ready), 64'd0);
            req_valid = 1'b1;
            req_base  = 32'h9999_0000;
         end else begin
            req_valid = 1'b0;
         end
         if (pat != 0 && cyc % 3 == 2) begin
            ret_valid = 1'b0;
         end else begin
            ret_valid = 1'b1;
            ret_idx   = 6'(arrival(order, n, k));
            ret_data  = line_val(tag, arrival(order, n, k));
            k++;
         end
         cyc++;
         @(negedge clk);
      end
      ret_valid = 1'b0;
      req_valid = 1'b0;
   endtask

   task automatic start_req(input int last, input logic [31:0] base);
      check(req_ready == 1'b1, "R2 ready", 64'(req_ready), 64'd1);
      req_valid = 1'b1;
      req_base  = base;
      req_last  = 6'(last);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic ret_one(input int idx, input int tag);
      ret_valid = 1'b1;
      ret_idx   = 6'(idx);
      ret_data  = line_val(tag, idx);
      @(negedge clk);
   endtask

   initial begin
      #(LIMIT * 5.0);
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", checks, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
      check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
      check(iss_valid == 1'b0, "R1 iss_valid", 64'(iss_valid), 64'd0);
      check(ret_err == 1'b0, "R1 ret_err", 64'(ret_err), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: orders and stall patterns (R3, R4, R5, R9 overlap)
      for (int v = 0; v < N_VEC; v++) begin
         start_req(VEC[v][0], 32'(VEC[v][3]));
         fork
            issue_expect(VEC[v][0] + 1, 32'(VEC[v][3]));
            feed(VEC[v][0] + 1, VEC[v][1], VEC[v][2], v + 1, VEC[v][4]);
            drain_expect(VEC[v][0] + 1, v + 1, VEC[v][2]);
         join
         check(req_ready == 1'b1, "R2 ready after last", 64'(req_ready), 64'd1);
      end

      // directed: drops, early hold, next-cycle visibility
      start_req(3, 32'h0000_8000);
      ret_one(2, 9);
      check(ret_err == 1'b0, "R8 good return", 64'(ret_err), 64'd0);
      ret_one(2, 8'hEE);                    // duplicate with junk
      check(ret_err == 1'b1, "R8 duplicate", 64'(ret_err), 64'd1);
      check(out_valid == 1'b0, "R5 early line held", 64'(out_valid), 64'd0);
      ret_one(5, 8'hEE);                    // beyond req_last
      check(ret_err == 1'b1, "R8 out of range", 64'(ret_err), 64'd1);
      ret_one(0, 9);
      ret_valid = 1'b0;
      check(ret_err == 1'b0, "R8 err one cycle", 64'(ret_err), 64'd0);
      check(out_valid == 1'b1, "R9 next cycle", 64'(out_valid), 64'd1);
      ret_one(1, 9);
      ret_one(3, 9);
      ret_valid = 1'b0;
      drain_expect(4, 9, 0);                // line 2 must carry tag 9, not junk (R8)
      check(req_ready == 1'b1, "R2 idle again", 64'(req_ready), 64'd1);
      ret_one(0, 8'hEE);                    // while idle
      ret_valid = 1'b0;
      check(ret_err == 1'b1, "R8 idle return", 64'(ret_err), 64'd1);
      check(out_valid == 1'b0, "R8 idle no output", 64'(out_valid), 64'd0);
      @(negedge clk);
      check(ret_err == 1'b0, "R8 err clears", 64'(ret_err), 64'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule